// File: doc/BRIEF.md
# Disk Controller Command Decoder and Status Multiplexer

This block sits behind the memory-mapped window of a floppy disk controller. Each access carries a 10-bit address. The top two bits pick one of four spaces: boot ROM, write data, drive orders or command. The block reports the chosen space as a one-hot strobe, which neighbouring blocks use.

In the command space, the low nibble of the address is an action code and the next nibble picks which status byte returns on the data bus. The block holds all the controller flags: sector flag, index, motor on, interrupt enable, and the window, read-enable and body phases. It also keeps a sector position for each drive. A programmable prescaler produces sector ticks. Each tick advances the selected drive through its sector phases, so the timing does not depend on how often software polls. The status byte always reflects the state as it stands after the access takes effect.

Top module: `fdc_cmd_status`

## Requirements
- R1: One cycle after an access, `space_o` is one-hot with bit `acc_addr[9:8]` set (0 ROM, 1 write data, 2 orders, 3 command). In a cycle with no access, `space_o` is zero.
- R2: Every command-space status byte carries, from bit 7 down: sector flag, index, a constant 1 for double density, and motor on.
- R3: `acc_addr[7:4]` selects the low half of a command-space result. Value 1 gives {window, read enable, 0, body}. Value 2 gives {write active, 0, write protect, track 0}. Value 3 gives the selected drive's 4-bit sector number. Value 4 returns the whole byte from `rd_byte`. Any other value gives a low nibble of 0.
- R4: Command codes in `acc_addr[3:0]`: 1 clears the sector flag, 2 clears interrupt enable, 3 sets it, 5 turns the motor on, 7 turns it off, and 0, 4 and 6 change no state. The status byte returned shows the state after the command.
- R5: Codes 8 to 15 change no state and still return the selected status byte.
- R6: While `presc_div` holds P, a sector tick occurs once every P+1 clock cycles.
- R7: On the selected drive's second tick within a sector, the window is set. On its third tick, read enable and body are set.
- R8: On the tenth tick, the drive's tick count returns to zero, the sector flag is set, window, read enable and body are cleared, and the drive's sector number advances.
- R9: Advancing from sector 9 wraps to 0 and sets index. Every other advance clears index.
- R10: Each drive keeps its own tick count and sector number. Only the drive named by `drv_sel` advances.
- R11: After reset, `dout`, `space_o`, `int_en` and `motor_on` are 0, and every flag, count and sector number is 0.
- R12: ROM-space accesses return `rom_byte`. Write-data and orders accesses return 0. Accesses outside the command space change no flag.
- R13: When a tick and a command land in the same cycle, the command's effect on a flag wins over the tick's.
- `dout` holds its value between accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe, one per access |
| acc_addr | input | 10 | Access address within the controller window |
| drv_sel | input | $clog2(NDRV) | Drive whose sector position advances and is reported |
| presc_div | input | PW | Prescaler divide value; tick period is value+1 cycles |
| rom_byte | input | 8 | Byte from the boot ROM for the current address |
| rd_byte | input | 8 | Next byte from the read-data path |
| wr_active | input | 1 | Write in progress, shown in view B |
| wprot | input | 1 | Write protect of the selected drive, shown in view B |
| trk0 | input | 1 | Track zero of the selected drive, shown in view B |
| dout | output | 8 | Registered result byte of the last access |
| space_o | output | 4 | One-hot space of the access in the previous cycle |
| int_en | output | 1 | Interrupt enable flag |
| motor_on | output | 1 | Motor-on flag |

## Verification
The bench builds the block with two drives and the default ten sectors of ten ticks. It sweeps the prescaler over 0, 1, 3 and 5, so a full revolution of 100 ticks, with index wrap, fits in a few hundred cycles. With two drives, alternating `drv_sel` shows that each drive keeps its own position. It sweeps all 16 codes against all 16 views in the command space and every view in the three other spaces. With a divide of 0, a tick lands on every cycle, so each clear-sector-flag command collides with a tick.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

  typedef enum logic [1:0] {
    SP_ROM    = 2'd0,
    SP_WDATA  = 2'd1,
    SP_ORDERS = 2'd2,
    SP_CMD    = 2'd3
  } space_e;

  typedef enum logic [3:0] {
    CMD_NOP       = 4'd0,
    CMD_CLR_SF    = 4'd1,
    CMD_IRQ_OFF   = 4'd2,
    CMD_IRQ_ON    = 4'd3,
    CMD_BODY      = 4'd4,
    CMD_MOTOR_ON  = 4'd5,
    CMD_WRITE     = 4'd6,
    CMD_MOTOR_OFF = 4'd7
  } cmd_e;

  typedef enum logic [3:0] {
    VW_A  = 4'd1,
    VW_B  = 4'd2,
    VW_C  = 4'd3,
    VW_RD = 4'd4
  } view_e;

  typedef struct packed {
    logic sf;
    logic ix;
    logic wi;
    logic re;
    logic bd;
    logic mo;
    logic ie;
  } flags_t;

endpackage

// File: rtl/fdc_tick_gen.sv
module fdc_tick_gen #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] div,
  output logic          tick
);

  logic [PW-1:0] pcnt_q;

  // A count that overshoots a lowered divide value still ends the period.
  assign tick = (pcnt_q >= div);

  always_ff @(posedge clk) begin
    if (rst)       pcnt_q <= '0;
    else if (tick) pcnt_q <= '0;
    else           pcnt_q <= pcnt_q + PW'(1);
  end

endmodule

// File: rtl/fdc_sector_seq.sv
module fdc_sector_seq #(
  parameter int NDRV       = 4,
  parameter int NSECT      = 10,
  parameter int SECT_TICKS = 10,
  parameter int WIN_AT     = 2,
  parameter int RE_AT      = 3,
  localparam int DW = (NDRV > 1) ? $clog2(NDRV) : 1,
  localparam int SW = (NSECT > 1) ? $clog2(NSECT) : 1,
  localparam int CW = $clog2(SECT_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [DW-1:0] drv_sel,
  output logic          ev_win,
  output logic          ev_rden,
  output logic          ev_sect,
  output logic          ev_wrap,
  output logic [SW-1:0] sec_cur,
  output logic [SW-1:0] sec_nxt
);

  logic [CW-1:0] cnt_arr [NDRV];
  logic [SW-1:0] sec_arr [NDRV];

  for (genvar d = 0; d < NDRV; d++) begin : g_drv
    logic [CW-1:0] cnt_q;
    logic [SW-1:0] sec_q;
    logic          adv;
    logic [CW-1:0] cnt_inc;
    logic          last;
    logic          wrap;

    assign adv     = tick && (drv_sel == DW'(d));
    assign cnt_inc = cnt_q + CW'(1);
    assign last    = (cnt_inc == CW'(SECT_TICKS));
    assign wrap    = (sec_q == SW'(NSECT - 1));

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q <= '0;
        sec_q <= '0;
      end else if (adv) begin
        cnt_q <= last ? '0 : cnt_inc;
        if (last) sec_q <= wrap ? '0 : sec_q + SW'(1);
      end
    end

    assign cnt_arr[d] = cnt_q;
    assign sec_arr[d] = sec_q;
  end

  logic [CW-1:0] sel_cnt;
  logic [CW-1:0] sel_inc;

  always_comb begin
    sel_cnt = '0;
    sec_cur = '0;
    for (int d = 0; d < NDRV; d++) begin
      if (drv_sel == DW'(d)) begin
        sel_cnt = cnt_arr[d];
        sec_cur = sec_arr[d];
      end
    end
  end

  // A drive_sel value beyond NDRV matches no drive and raises no event.
  logic sel_ok;
  always_comb begin
    sel_ok = 1'b0;
    for (int d = 0; d < NDRV; d++)
      if (drv_sel == DW'(d)) sel_ok = 1'b1;
  end

  assign sel_inc = sel_cnt + CW'(1);
  assign ev_win  = tick && sel_ok && (sel_inc == CW'(WIN_AT));
  assign ev_rden = tick && sel_ok && (sel_inc == CW'(RE_AT));
  assign ev_sect = tick && sel_ok && (sel_inc == CW'(SECT_TICKS));
  assign ev_wrap = ev_sect && (sec_cur == SW'(NSECT - 1));
  assign sec_nxt = !ev_sect ? sec_cur : (ev_wrap ? '0 : sec_cur + SW'(1));

endmodule

// File: rtl/fdc_flag_regs.sv
module fdc_flag_regs
  import fdc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       acc_cmd,
  input  logic [3:0] code,
  input  logic       ev_win,
  input  logic       ev_rden,
  input  logic       ev_sect,
  input  logic       ev_wrap,
  output flags_t     flg_q,
  output flags_t     flg_n
);

  always_comb begin
    flg_n = flg_q;
    // Sector timing events first, so a command in the same cycle overrides.
    if (ev_win)  flg_n.wi = 1'b1;
    if (ev_rden) begin
      flg_n.re = 1'b1;
      flg_n.bd = 1'b1;
    end
    if (ev_sect) begin
      flg_n.sf = 1'b1;
      flg_n.wi = 1'b0;
      flg_n.re = 1'b0;
      flg_n.bd = 1'b0;
      flg_n.ix = ev_wrap;
    end
    if (acc_cmd) begin
      case (code)
        CMD_CLR_SF:    flg_n.sf = 1'b0;
        CMD_IRQ_OFF:   flg_n.ie = 1'b0;
        CMD_IRQ_ON:    flg_n.ie = 1'b1;
        CMD_MOTOR_ON:  flg_n.mo = 1'b1;
        CMD_MOTOR_OFF: flg_n.mo = 1'b0;
        default:       ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flg_q <= '0;
    else     flg_q <= flg_n;
  end

endmodule

// File: rtl/fdc_status_mux.sv
module fdc_status_mux
  import fdc_pkg::*;
#(
  parameter int SW = 4
) (
  input  flags_t        flg,
  input  logic [3:0]    view,
  input  logic          wr_active,
  input  logic          wprot,
  input  logic          trk0,
  input  logic [SW-1:0] sec,
  input  logic [7:0]    rd_byte,
  output logic [7:0]    stat
);

  logic [3:0] upper;
  assign upper = {flg.sf, flg.ix, 1'b1, flg.mo};

  always_comb begin
    case (view)
      VW_A:    stat = {upper, flg.wi, flg.re, 1'b0, flg.bd};
      VW_B:    stat = {upper, wr_active, 1'b0, wprot, trk0};
      VW_C:    stat = {upper, 4'(sec)};
      VW_RD:   stat = rd_byte;
      default: stat = {upper, 4'b0000};
    endcase
  end

endmodule

// File: rtl/fdc_cmd_status.sv
module fdc_cmd_status
  import fdc_pkg::*;
#(
  parameter int NDRV       = 4,
  parameter int NSECT      = 10,
  parameter int SECT_TICKS = 10,
  parameter int WIN_AT     = 2,
  parameter int RE_AT      = 3,
  parameter int PW         = 8,
  localparam int DW = (NDRV > 1) ? $clog2(NDRV) : 1,
  localparam int SW = (NSECT > 1) ? $clog2(NSECT) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_valid,
  input  logic [9:0]    acc_addr,
  input  logic [DW-1:0] drv_sel,
  input  logic [PW-1:0] presc_div,
  input  logic [7:0]    rom_byte,
  input  logic [7:0]    rd_byte,
  input  logic          wr_active,
  input  logic          wprot,
  input  logic          trk0,
  output logic [7:0]    dout,
  output logic [3:0]    space_o,
  output logic          int_en,
  output logic          motor_on
);

  space_e        space;
  logic          acc_cmd;
  logic          tick;
  logic          ev_win, ev_rden, ev_sect, ev_wrap;
  logic [SW-1:0] sec_cur, sec_nxt;
  flags_t        flg_q, flg_n;
  logic [7:0]    stat;
  logic [7:0]    byte_sel;

  assign space   = space_e'(acc_addr[9:8]);
  assign acc_cmd = acc_valid && (space == SP_CMD);

  fdc_tick_gen #(.PW(PW)) i_tick (
    .clk  (clk),
    .rst  (rst),
    .div  (presc_div),
    .tick (tick)
  );

  fdc_sector_seq #(
    .NDRV(NDRV), .NSECT(NSECT), .SECT_TICKS(SECT_TICKS),
    .WIN_AT(WIN_AT), .RE_AT(RE_AT)
  ) i_seq (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .drv_sel (drv_sel),
    .ev_win  (ev_win),
    .ev_rden (ev_rden),
    .ev_sect (ev_sect),
    .ev_wrap (ev_wrap),
    .sec_cur (sec_cur),
    .sec_nxt (sec_nxt)
  );

  fdc_flag_regs i_flags (
    .clk     (clk),
    .rst     (rst),
    .acc_cmd (acc_cmd),
    .code    (acc_addr[3:0]),
    .ev_win  (ev_win),
    .ev_rden (ev_rden),
    .ev_sect (ev_sect),
    .ev_wrap (ev_wrap),
    .flg_q   (flg_q),
    .flg_n   (flg_n)
  );

  fdc_status_mux #(.SW(SW)) i_mux (
    .flg       (flg_n),
    .view      (acc_addr[7:4]),
    .wr_active (wr_active),
    .wprot     (wprot),
    .trk0      (trk0),
    .sec       (sec_nxt),
    .rd_byte   (rd_byte),
    .stat      (stat)
  );

  always_comb begin
    case (space)
      SP_ROM:  byte_sel = rom_byte;
      SP_CMD:  byte_sel = stat;
      default: byte_sel = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      space_o <= '0;
    end else begin
      space_o <= acc_valid ? (4'b0001 << acc_addr[9:8]) : 4'b0000;
      if (acc_valid) dout <= byte_sel;
    end
  end

  assign int_en   = flg_q.ie;
  assign motor_on = flg_q.mo;

endmodule

// File: rtl/fdc_cmd_status_chk.sv
module fdc_cmd_status_chk #(
  parameter int NSECT = 10,
  parameter int SW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          acc_valid,
  input logic [9:0]    acc_addr,
  input logic [3:0]    space_o,
  input logic [7:0]    dout,
  input logic          int_en,
  input logic          motor_on,
  input logic          ev_sect,
  input logic          sf_q,
  input logic [SW-1:0] sec_sel
);

  a_r1_space_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(space_o));

  a_r1_cmd_space: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_addr[9:8] == 2'd3) |=> (space_o == 4'b1000));

  a_r2_density_one: assert property (@(posedge clk) disable iff (rst)
    (space_o[3] && $past(acc_addr[7:4]) != 4'd4) |-> dout[5]);

  a_r4_irq_arm: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_addr[9:8] == 2'd3 && acc_addr[3:0] == 4'd3) |=> int_en);

  a_r5_unsupported_hold: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_addr[9:8] == 2'd3 && acc_addr[3]) |=>
      ($stable(int_en) && $stable(motor_on)));

  a_r8_sector_flag_set: assert property (@(posedge clk) disable iff (rst)
    (ev_sect && !(acc_valid && acc_addr[9:8] == 2'd3 && acc_addr[3:0] == 4'd1))
      |=> sf_q);

  a_r9_sector_range: assert property (@(posedge clk) disable iff (rst)
    (sec_sel < SW'(NSECT)));

  a_r11_reset_outputs: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dout == 8'h00 && space_o == 4'b0000 && !int_en && !motor_on));

endmodule

bind fdc_cmd_status fdc_cmd_status_chk #(.NSECT(NSECT), .SW(SW)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .acc_valid (acc_valid),
  .acc_addr  (acc_addr),
  .space_o   (space_o),
  .dout      (dout),
  .int_en    (int_en),
  .motor_on  (motor_on),
  .ev_sect   (ev_sect),
  .sf_q      (flg_q.sf),
  .sec_sel   (sec_cur)
);

// File: tb/test_fdc_cmd_status.sv
module test_fdc_cmd_status;

  localparam int NDRV  = 2;
  localparam int NSECT = 10;
  localparam int STK   = 10;
  localparam int WIN   = 2;
  localparam int REA   = 3;
  localparam int PW    = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          acc_valid = 1'b0;
  logic [9:0]    acc_addr = '0;
  logic [0:0]    drv_sel = '0;
  logic [PW-1:0] presc_div = '0;
  logic [7:0]    rom_byte = '0;
  logic [7:0]    rd_byte = '0;
  logic          wr_active = 1'b0;
  logic          wprot = 1'b0;
  logic          trk0 = 1'b0;
  logic [7:0]    dout;
  logic [3:0]    space_o;
  logic          int_en;
  logic          motor_on;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fdc_cmd_status #(
    .NDRV(NDRV), .NSECT(NSECT), .SECT_TICKS(STK),
    .WIN_AT(WIN), .RE_AT(REA), .PW(PW)
  ) i_fdc_cmd_status (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .drv_sel(drv_sel), .presc_div(presc_div), .rom_byte(rom_byte),
    .rd_byte(rd_byte), .wr_active(wr_active), .wprot(wprot), .trk0(trk0),
    .dout(dout), .space_o(space_o), .int_en(int_en), .motor_on(motor_on)
  );

  // Reference model written from the requirements.
  int   m_pc;
  int   m_cnt [NDRV];
  int   m_sec [NDRV];
  logic m_sf, m_ix, m_wi, m_re, m_bd, m_mo, m_ie;
  logic [7:0] e_dout;
  logic [3:0] e_space;

  always @(posedge clk) begin
    if (rst) begin
      m_pc = 0;
      for (int d = 0; d < NDRV; d++) begin m_cnt[d] = 0; m_sec[d] = 0; end
      {m_sf, m_ix, m_wi, m_re, m_bd, m_mo, m_ie} = '0;
      e_dout = 8'h00;
      e_space = 4'h0;
    end else begin
      int  d, c;
      logic t;
      logic [3:0] up, lo;
      d = int'(drv_sel);
      t = (m_pc >= int'(presc_div));
      m_pc = t ? 0 : m_pc + 1;
      if (t) begin
        c = m_cnt[d] + 1;
        if (c == STK) begin
          m_cnt[d] = 0;
          m_sf = 1; m_wi = 0; m_re = 0; m_bd = 0;
          if (m_sec[d] == NSECT - 1) begin m_sec[d] = 0; m_ix = 1; end
          else begin m_sec[d] = m_sec[d] + 1; m_ix = 0; end
        end else begin
          m_cnt[d] = c;
          if (c == WIN) m_wi = 1;
          if (c == REA) begin m_re = 1; m_bd = 1; end
        end
      end
      e_space = 4'h0;
      if (acc_valid) begin
        e_space[acc_addr[9:8]] = 1'b1;
        if (acc_addr[9:8] == 2'd3) begin
          case (acc_addr[3:0])
            4'd1: m_sf = 0;
            4'd2: m_ie = 0;
            4'd3: m_ie = 1;
            4'd5: m_mo = 1;
            4'd7: m_mo = 0;
            default: ;
          endcase
          up = {m_sf, m_ix, 1'b1, m_mo};
          case (acc_addr[7:4])
            4'd1: lo = {m_wi, m_re, 1'b0, m_bd};
            4'd2: lo = {wr_active, 1'b0, wprot, trk0};
            4'd3: lo = 4'(m_sec[d]);
            default: lo = 4'h0;
          endcase
          e_dout = (acc_addr[7:4] == 4'd4) ? rd_byte : {up, lo};
        end else if (acc_addr[9:8] == 2'd0) begin
          e_dout = rom_byte;
        end else begin
          e_dout = 8'h00;
        end
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    acc_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // One access; result checked at the following falling edge.
  task automatic access(input logic [9:0] a, input string tag);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_addr  = a;
    rom_byte  = a[7:0] ^ 8'hC3;
    rd_byte   = {a[3:0], a[7:4]} ^ 8'h5A;
    wr_active = a[4];
    wprot     = a[5] ^ a[0];
    trk0      = a[6] ^ a[1];
    @(negedge clk);
    acc_valid = 1'b0;
    chk(tag, "dout", dout, e_dout);
    chk("R1", "space", {4'h0, space_o}, {4'h0, e_space});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not end, actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R11: reset state
    presc_div = 8'd2;
    do_reset();
    @(negedge clk);
    chk("R11", "dout", dout, 8'h00);
    chk("R11", "space", {4'h0, space_o}, 8'h00);
    chk("R11", "int_en", {7'h0, int_en}, 8'h00);
    chk("R11", "motor_on", {7'h0, motor_on}, 8'h00);
    access({2'd3, 4'd3, 4'd0}, "R11");

    // Command x view sweep: R2, R3, R4, R5, R13
    for (int code = 0; code < 16; code++) begin
      for (int v = 0; v < 16; v++) begin
        access({2'd3, 4'(v), 4'(code)}, code >= 8 ? "R5" : (v == 4 ? "R3" : "R4"));
        if (v != 4) chk("R2", "upper nibble", {4'h0, dout[7:4]},
                        {4'h0, m_sf, m_ix, 1'b1, m_mo});
        chk(code >= 8 ? "R5" : "R4", "int_en", {7'h0, int_en}, {7'h0, m_ie});
        chk(code >= 8 ? "R5" : "R4", "motor_on", {7'h0, motor_on}, {7'h0, m_mo});
      end
    end

    // Directed motor and interrupt commands
    access({2'd3, 4'd3, 4'd5}, "R4");
    chk("R4", "motor on bit", {7'h0, dout[4]}, 8'h01);
    access({2'd3, 4'd3, 4'd7}, "R4");
    chk("R4", "motor off bit", {7'h0, dout[4]}, 8'h00);
    access({2'd3, 4'd0, 4'd3}, "R4");
    chk("R4", "irq armed", {7'h0, int_en}, 8'h01);
    access({2'd3, 4'd0, 4'd2}, "R4");
    chk("R4", "irq disarmed", {7'h0, int_en}, 8'h00);
    access({2'd3, 4'd0, 4'd5}, "R4");

    // Non-command spaces: R12
    for (int sp = 0; sp < 3; sp++) begin
      for (int v = 0; v < 64; v++) begin
        access({2'(sp), 8'(v * 4 + 3)}, "R12");
        chk("R12", "motor kept", {7'h0, motor_on}, 8'h01);
        chk("R12", "int_en kept", {7'h0, int_en}, 8'h00);
      end
    end
    access({2'd3, 4'd3, 4'd0}, "R12");

    // Sector sequencing with a tick every cycle: R7, R8, R9, R13
    presc_div = 8'd0;
    do_reset();
    for (int i = 0; i < 260; i++) begin
      if (i % 23 == 11)      access({2'd3, 4'd3, 4'd1}, "R13");
      else if (i % 2 == 0)   access({2'd3, 4'd3, 4'd0}, "R9");
      else                   access({2'd3, 4'd1, 4'd0}, "R7");
      if (i % 2 == 0) chk("R8", "sector flag", {7'h0, dout[7]}, {7'h0, m_sf});
    end

    // Per-drive positions: R10
    for (int i = 0; i < 200; i++) begin
      if (i % 37 == 0) drv_sel = ~drv_sel;
      access({2'd3, 4'd3, 4'd0}, "R10");
    end

    // Prescaler periods: R6
    for (int p = 1; p < 6; p += 2) begin
      presc_div = 8'(p);
      do_reset();
      for (int i = 0; i < 90; i++)
        access({2'd3, (i % 2 == 0) ? 4'd1 : 4'd3, 4'd0}, "R6");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule